// File: doc/BRIEF.md
# Interrupt Pin Acceptance and Delivery Core

This block keeps the request state for every interrupt input pin of a routing controller. Each pin arrives with a strobe and a raw level. The block corrects the level for the pin's polarity and updates the pin's request bit. It then decides whether the event needs a delivery or is merged into one that is already outstanding. The routing table is not stored here. Its fields are presented on inputs: vector, destination, destination mode, trigger mode, delivery mode, polarity and mask.

Deliveries leave on a valid/ready channel, one at a time. A level-triggered pin whose delivery was accepted stays blocked until an end-of-interrupt names its vector. After that the pin is re-serviced if its request is still active. A write strobe tells the block that a table entry changed. The write may trigger a service, may clear the remote-pending flag, and may produce a mask-change notice. A 256-bit map of the vectors present in the table is rebuilt after each write.

Top module: `irq_pin_router`

## Requirements
- R1: The effective level is the raw level XOR the entry's polarity bit. A strobe with effective level 1 on an idle, unmasked edge pin whose request bit is 0 puts a delivery on the output two clock edges later. A strobe with effective level 0 only clears the request bit: no delivery and no merged pulse follow.
- R2: An edge pin is serviced only when the request bit goes from 0 to 1. A strobe with effective level 1 while the bit is already 1 raises that pin's bit of `irq_merged` for one cycle, one edge after the strobe.
- R3: A level pin (trigger bit 1) is serviced on a strobe with effective level 1 only while its remote-pending flag is clear. The flag is set when a level delivery is accepted. Strobes that arrive while the flag is set produce a merged pulse.
- R4: A masked pin never produces a delivery or a merged pulse. Its request bit still follows the strobes.
- R5: While `dlv_valid` is high and `dlv_ready` is low, the pin index and all payload fields hold steady. A transfer completes on an edge where both are high. The payload carries the entry's vector, destination, destination mode, trigger bit and 3-bit delivery mode.
- R6: A level-type end-of-interrupt clears the remote-pending flag of every level entry whose vector equals `eoi_vec`. Each such entry that is unmasked and still has its request bit set is delivered again. An end-of-interrupt with a non-matching vector, or with `eoi_level` low, changes nothing.
- R7: A table write to a level entry that is unmasked and has its request bit set services that pin. A write to the low half (`wr_low`=1) clears the entry's remote-pending flag.
- R8: When a write changes an entry's mask bit, `mchg_valid` pulses one edge later, with the pin index and the new mask value. A write that leaves the mask unchanged gives no pulse.
- R9: On the first edge after reset, and on the edge after each table write, bit v of `vec_map` is set exactly when some entry holds vector v. During reset the map is all zero.
- R10: When several pins wait for service, they are delivered one at a time, lowest pin index first.
- R11: During reset, `dlv_valid`, `irq_merged` and `mchg_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_strobe | input | NPINS | Per-pin level report strobe |
| pin_raw | input | NPINS | Per-pin raw level, sampled with the strobe |
| ent_vector | input | NPINS*8 | Vector of each entry, pin 0 in the low byte |
| ent_dest | input | NPINS*8 | Destination of each entry |
| ent_dmode | input | NPINS | Destination mode of each entry |
| ent_trig | input | NPINS | Trigger mode, 1 = level |
| ent_mode | input | NPINS*3 | Delivery mode of each entry |
| ent_pol | input | NPINS | Polarity, 1 = inverted |
| ent_mask | input | NPINS | Mask, 1 = masked |
| wr_en | input | 1 | Table entry write strobe |
| wr_idx | input | IW | Index of the written entry |
| wr_low | input | 1 | Write targets the low half of the entry |
| eoi_en | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | End-of-interrupt vector |
| eoi_level | input | 1 | End-of-interrupt is level type |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery request accepted |
| dlv_pin | output | IW | Pin being delivered |
| dlv_vector | output | 8 | Delivered vector |
| dlv_dest | output | 8 | Delivered destination |
| dlv_dmode | output | 1 | Delivered destination mode |
| dlv_trig | output | 1 | Delivered trigger mode |
| dlv_mode | output | 3 | Delivered delivery mode |
| irq_merged | output | NPINS | One-cycle merged-event pulse per pin |
| mchg_valid | output | 1 | Mask-change notice |
| mchg_idx | output | IW | Pin whose mask changed |
| mchg_mask | output | 1 | New mask value |
| vec_map | output | 256 | Vectors present in the table |

## Verification
A pin strobe is captured on edge A. Its merged pulse is visible just after A. A delivery it starts is granted on edge B, so `dlv_valid` is sampled at the falling edge after B. End-of-interrupt and table-write services follow the same two-edge path. Mask notices and map rebuilds appear one edge after the write. After an accepted transfer, the next waiting pin is granted on the following edge. The bench drives all stimulus on falling edges and checks each result at the exact falling edge this count predicts. It also checks that nothing appears in the windows where no result is due.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;
  localparam int MAP_W  = 1 << VEC_W;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [DEST_W-1:0] dest;
    logic              dmode;
    logic              trig;
    logic [MODE_W-1:0] mode;
  } dlv_req_t;

  function automatic logic eff_level(input logic raw, input logic pol);
    return raw ^ pol;
  endfunction

  function automatic logic wants_service(input logic eff, input logic trig,
                                         input logic irr, input logic rp);
    return eff && (trig ? !rp : !irr);
  endfunction
endpackage

// File: rtl/pin_eval.sv
module pin_eval (
  input  logic strobe,
  input  logic raw,
  input  logic pol,
  input  logic trig,
  input  logic mask,
  input  logic irr,
  input  logic rp,
  input  logic pend,
  output logic irr_nx,
  output logic need,
  output logic merge
);
  import irqr_pkg::*;
  logic eff, cand;

  always_comb begin
    eff    = eff_level(raw, pol);
    cand   = wants_service(eff, trig, irr, rp) && !pend;
    irr_nx = strobe ? eff : irr;
    need   = strobe && !mask && cand;
    merge  = strobe && !mask && eff && !cand;
  end
endmodule

// File: rtl/svc_arbiter.sv
module svc_arbiter #(
  parameter  int NPINS = 8,
  localparam int IW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NPINS-1:0]                      req,
  input  logic [NPINS*irqr_pkg::VEC_W-1:0]      vec_f,
  input  logic [NPINS*irqr_pkg::DEST_W-1:0]     dest_f,
  input  logic [NPINS-1:0]                      dmode_f,
  input  logic [NPINS-1:0]                      trig_f,
  input  logic [NPINS*irqr_pkg::MODE_W-1:0]     mode_f,
  input  logic                                  ready,
  output logic                                  valid,
  output logic [IW-1:0]                         pin,
  output irqr_pkg::dlv_req_t                    pay,
  output logic [NPINS-1:0]                      done
);
  import irqr_pkg::*;
  logic          busy_q;
  logic [IW-1:0] cur_q, sel;
  dlv_req_t      pay_q;

  always_comb begin
    sel = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (req[i]) sel = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      pay_q  <= '0;
    end else if (!busy_q && |req) begin
      busy_q       <= 1'b1;
      cur_q        <= sel;
      pay_q.vector <= vec_f[int'(sel)*VEC_W +: VEC_W];
      pay_q.dest   <= dest_f[int'(sel)*DEST_W +: DEST_W];
      pay_q.dmode  <= dmode_f[sel];
      pay_q.trig   <= trig_f[sel];
      pay_q.mode   <= mode_f[int'(sel)*MODE_W +: MODE_W];
    end else if (busy_q && ready) begin
      busy_q <= 1'b0;
    end
  end

  assign valid = busy_q;
  assign pin   = cur_q;
  assign pay   = pay_q;
  assign done  = (busy_q && ready) ? (NPINS'(1) << cur_q) : '0;

  a_r5_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready) |=> (busy_q && $stable(pay_q) && $stable(cur_q)));

  a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !$past(busy_q)) |->
      (($past(req) & ((NPINS'(1) << cur_q) - NPINS'(1))) == '0));
endmodule

// File: rtl/vec_bitmap.sv
module vec_bitmap #(
  parameter int NPINS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rebuild,
  input  logic [NPINS*irqr_pkg::VEC_W-1:0]  vec_f,
  output logic [irqr_pkg::MAP_W-1:0]        map
);
  import irqr_pkg::*;
  logic             first_q;
  logic [MAP_W-1:0] map_q, nxt;

  always_comb begin
    nxt = '0;
    for (int i = 0; i < NPINS; i++) nxt[vec_f[i*VEC_W +: VEC_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      map_q   <= '0;
    end else begin
      first_q <= 1'b0;
      if (rebuild || first_q) map_q <= nxt;
    end
  end

  assign map = map_q;

  a_r9_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(rebuild || first_q) |=> $stable(map_q));

  a_r9_entry0_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (rebuild || first_q) |=> map_q[$past(vec_f[VEC_W-1:0])]);
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router #(
  parameter  int NPINS = 8,
  localparam int IW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NPINS-1:0]                      pin_strobe,
  input  logic [NPINS-1:0]                      pin_raw,
  input  logic [NPINS*irqr_pkg::VEC_W-1:0]      ent_vector,
  input  logic [NPINS*irqr_pkg::DEST_W-1:0]     ent_dest,
  input  logic [NPINS-1:0]                      ent_dmode,
  input  logic [NPINS-1:0]                      ent_trig,
  input  logic [NPINS*irqr_pkg::MODE_W-1:0]     ent_mode,
  input  logic [NPINS-1:0]                      ent_pol,
  input  logic [NPINS-1:0]                      ent_mask,
  input  logic                                  wr_en,
  input  logic [IW-1:0]                         wr_idx,
  input  logic                                  wr_low,
  input  logic                                  eoi_en,
  input  logic [irqr_pkg::VEC_W-1:0]            eoi_vec,
  input  logic                                  eoi_level,
  output logic                                  dlv_valid,
  input  logic                                  dlv_ready,
  output logic [IW-1:0]                         dlv_pin,
  output logic [irqr_pkg::VEC_W-1:0]            dlv_vector,
  output logic [irqr_pkg::DEST_W-1:0]           dlv_dest,
  output logic                                  dlv_dmode,
  output logic                                  dlv_trig,
  output logic [irqr_pkg::MODE_W-1:0]           dlv_mode,
  output logic [NPINS-1:0]                      irq_merged,
  output logic                                  mchg_valid,
  output logic [IW-1:0]                         mchg_idx,
  output logic                                  mchg_mask,
  output logic [irqr_pkg::MAP_W-1:0]            vec_map
);
  import irqr_pkg::*;

  logic [NPINS-1:0] irr_q, rp_q, pend_q, mask_q, merged_q;
  logic [NPINS-1:0] irr_nx, need, merge, eoi_hit, wr_hit, resvc, wr_svc;
  logic [NPINS-1:0] done, inflight, req;
  logic             mchg_q, mchg_m_q;
  logic [IW-1:0]    mchg_i_q;
  dlv_req_t         pay;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_eval u_eval (
      .strobe(pin_strobe[p]), .raw(pin_raw[p]), .pol(ent_pol[p]),
      .trig(ent_trig[p]), .mask(ent_mask[p]), .irr(irr_q[p]),
      .rp(rp_q[p]), .pend(pend_q[p]), .irr_nx(irr_nx[p]),
      .need(need[p]), .merge(merge[p])
    );
    assign eoi_hit[p] = eoi_en && eoi_level && ent_trig[p] &&
                        (ent_vector[p*VEC_W +: VEC_W] == eoi_vec);
    assign resvc[p]   = eoi_hit[p] && !ent_mask[p] && irr_q[p];
    assign wr_hit[p]  = wr_en && (wr_idx == IW'(p));
    assign wr_svc[p]  = wr_hit[p] && ent_trig[p] && irr_q[p] && !ent_mask[p];
  end

  assign inflight = dlv_valid ? (NPINS'(1) << dlv_pin) : '0;
  assign req      = pend_q & ~ent_mask;

  svc_arbiter #(.NPINS(NPINS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req),
    .vec_f(ent_vector), .dest_f(ent_dest), .dmode_f(ent_dmode),
    .trig_f(ent_trig), .mode_f(ent_mode), .ready(dlv_ready),
    .valid(dlv_valid), .pin(dlv_pin), .pay(pay), .done(done)
  );

  vec_bitmap #(.NPINS(NPINS)) u_map (
    .clk(clk), .rst_n(rst_n), .rebuild(wr_en), .vec_f(ent_vector), .map(vec_map)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q    <= '0;
      rp_q     <= '0;
      pend_q   <= '0;
      mask_q   <= '0;
      merged_q <= '0;
      mchg_q   <= 1'b0;
      mchg_i_q <= '0;
      mchg_m_q <= 1'b0;
    end else begin
      irr_q    <= irr_nx;
      pend_q   <= ((pend_q & ~done) | need | resvc | wr_svc) & ~(ent_mask & ~inflight);
      rp_q     <= (rp_q & ~eoi_hit & ~(wr_hit & {NPINS{wr_low}})) |
                  (done & {NPINS{pay.trig}});
      mask_q   <= ent_mask;
      merged_q <= merge;
      mchg_q   <= wr_en && (ent_mask[wr_idx] != mask_q[wr_idx]);
      mchg_i_q <= wr_idx;
      mchg_m_q <= ent_mask[wr_idx];
    end
  end

  assign dlv_vector = pay.vector;
  assign dlv_dest   = pay.dest;
  assign dlv_dmode  = pay.dmode;
  assign dlv_trig   = pay.trig;
  assign dlv_mode   = pay.mode;
  assign irq_merged = merged_q;
  assign mchg_valid = mchg_q;
  assign mchg_idx   = mchg_i_q;
  assign mchg_mask  = mchg_m_q;

  a_r2_merge_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_merged) |-> ((irq_merged & ~$past(pin_strobe)) == '0));

  a_r4_no_merge_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_merged) |-> ((irq_merged & $past(ent_mask)) == '0));

  a_r3_flag_after_level_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (|done && dlv_trig) |=> rp_q[$past(dlv_pin)]);

  a_r8_notice_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    mchg_valid |-> $past(wr_en));
endmodule

// File: tb/irq_pin_router_tb_top.sv
`timescale 1ns/1ps
module irq_pin_router_tb_top;
  localparam int NP = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0] pin_strobe = '0, pin_raw = '0;
  logic [7:0] tvec [NP];
  logic [7:0] tdest [NP];
  logic [2:0] tmode [NP];
  logic [NP-1:0] tdm, ttrig, tpol, tmask;
  logic [NP*8-1:0] vec_f, dest_f;
  logic [NP*3-1:0] mode_f;
  logic wr_en = 0, wr_low = 0, eoi_en = 0, eoi_level = 0, dlv_ready = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [7:0] eoi_vec = '0;
  logic dlv_valid, dlv_dmode, dlv_trig, mchg_valid, mchg_mask;
  logic [IW-1:0] dlv_pin, mchg_idx;
  logic [7:0] dlv_vector, dlv_dest;
  logic [2:0] dlv_mode;
  logic [NP-1:0] irq_merged;
  logic [255:0] vec_map;
  int nchk = 0, nerr = 0;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      vec_f[i*8 +: 8]  = tvec[i];
      dest_f[i*8 +: 8] = tdest[i];
      mode_f[i*3 +: 3] = tmode[i];
    end
  end

  irq_pin_router #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_strobe(pin_strobe), .pin_raw(pin_raw),
    .ent_vector(vec_f), .ent_dest(dest_f), .ent_dmode(tdm), .ent_trig(ttrig),
    .ent_mode(mode_f), .ent_pol(tpol), .ent_mask(tmask),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_low(wr_low),
    .eoi_en(eoi_en), .eoi_vec(eoi_vec), .eoi_level(eoi_level),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_dmode(dlv_dmode),
    .dlv_trig(dlv_trig), .dlv_mode(dlv_mode), .irq_merged(irq_merged),
    .mchg_valid(mchg_valid), .mchg_idx(mchg_idx), .mchg_mask(mchg_mask),
    .vec_map(vec_map)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_map();
    logic [255:0] m = '0;
    for (int i = 0; i < NP; i++) m[tvec[i]] = 1'b1;
    return m;
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic strobe(input logic [NP-1:0] pins, input logic raw);
    for (int i = 0; i < NP; i++) if (pins[i]) pin_raw[i] = raw;
    pin_strobe = pins;
    step();
    pin_strobe = '0;
  endtask

  task automatic expect_dlv(input string tag, input int p);
    chk({tag, " valid"}, 64'(dlv_valid), 64'd1);
    chk({tag, " pin"}, 64'(dlv_pin), 64'(p));
    chk({tag, " payload"}, {dlv_vector, dlv_dest, 4'(dlv_mode), 3'd0, dlv_dmode, 3'd0, dlv_trig},
        {tvec[p], tdest[p], 4'(tmode[p]), 3'd0, tdm[p], 3'd0, ttrig[p]});
  endtask

  task automatic accept();
    dlv_ready = 1'b1;
    step();
    dlv_ready = 1'b0;
  endtask

  task automatic t_reset();
    step();
    chk("R11 valid in reset", 64'(dlv_valid), 0);
    chk("R11 merged in reset", 64'(irq_merged), 0);
    chk("R11 mchg in reset", 64'(mchg_valid), 0);
    chk("R9 map zero in reset", 64'(vec_map != 0), 0);
    rst_n = 1'b1;
    step();
    chk("R9 map after reset", 64'(vec_map == exp_map()), 1);
  endtask

  task automatic t_polarity();
    strobe(8'h01, 1'b1);
    chk("R1 no merge on first rise", 64'(irq_merged), 0);
    step();
    expect_dlv("R1 edge pin0", 0);
    accept();
    chk("R5 valid drops after accept", 64'(dlv_valid), 0);
    strobe(8'h01, 1'b0);
    chk("R1 low level no merge", 64'(irq_merged), 0);
    step();
    chk("R1 low level no delivery", 64'(dlv_valid), 0);
    strobe(8'h02, 1'b0);
    step();
    expect_dlv("R1 inverted pin1", 1);
    accept();
  endtask

  task automatic t_edge_merge();
    strobe(8'h01, 1'b1);
    step();
    expect_dlv("R2 new rise pin0", 0);
    accept();
    strobe(8'h01, 1'b1);
    chk("R2 repeat level merged", 64'(irq_merged), 64'h01);
    step();
    chk("R2 repeat no delivery", 64'(dlv_valid), 0);
  endtask

  task automatic t_level_hold();
    strobe(8'h04, 1'b1);
    step();
    expect_dlv("R3 level pin2", 2);
    for (int k = 0; k < 3; k++) begin
      step();
      expect_dlv("R5 held while not ready", 2);
    end
    accept();
    strobe(8'h04, 1'b1);
    chk("R3 merged while flag set", 64'(irq_merged), 64'h04);
    step();
    chk("R3 no delivery while flag set", 64'(dlv_valid), 0);
  endtask

  task automatic t_eoi();
    eoi_en = 1; eoi_vec = 8'h55; eoi_level = 1;
    step();
    eoi_vec = 8'h22; eoi_level = 0;
    step();
    eoi_en = 0;
    step(); step();
    chk("R6 wrong or edge EOI ignored", 64'(dlv_valid), 0);
    eoi_en = 1; eoi_vec = 8'h22; eoi_level = 1;
    step();
    eoi_en = 0;
    step();
    expect_dlv("R6 redelivery after EOI", 2);
    accept();
  endtask

  task automatic t_write_service();
    wr_en = 1; wr_idx = 3'd2; wr_low = 1;
    step();
    wr_en = 0; wr_low = 0;
    step();
    expect_dlv("R7 write services level pin", 2);
    accept();
    strobe(8'h04, 1'b1);
    chk("R7 flag set again after accept", 64'(irq_merged), 64'h04);
  endtask

  task automatic t_mask();
    tmask[3] = 1'b1; wr_en = 1; wr_idx = 3'd3;
    step();
    wr_en = 0;
    chk("R8 notice on mask change", {mchg_valid, 4'(mchg_idx), mchg_mask}, {1'b1, 4'd3, 1'b1});
    wr_en = 1;
    step();
    wr_en = 0;
    chk("R8 no notice when unchanged", 64'(mchg_valid), 0);
    strobe(8'h08, 1'b1);
    chk("R4 masked no merge", 64'(irq_merged), 0);
    step(); step();
    chk("R4 masked no delivery", 64'(dlv_valid), 0);
  endtask

  task automatic t_map();
    chk("R9 new vector absent before write", 64'(vec_map[8'h90]), 0);
    tvec[5] = 8'h90; wr_en = 1; wr_idx = 3'd5;
    step();
    wr_en = 0;
    chk("R9 new vector set", 64'(vec_map[8'h90]), 1);
    chk("R9 old vector cleared", 64'(vec_map[8'h25]), 0);
    chk("R9 whole map", 64'(vec_map == exp_map()), 1);
  endtask

  task automatic t_order();
    strobe(8'hD0, 1'b1);
    step();
    expect_dlv("R10 first lowest", 4);
    accept(); step();
    expect_dlv("R10 second", 6);
    accept(); step();
    expect_dlv("R10 third", 7);
    accept(); step();
    chk("R10 queue empty", 64'(dlv_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      tvec[i] = 8'h20 + 8'(i);
      tdest[i] = 8'h40 + 8'(i);
      tmode[i] = 3'(i);
    end
    tdm = 8'hAA; ttrig = 8'h04; tpol = 8'h02; tmask = '0;
    t_reset();
    t_polarity();
    t_edge_merge();
    t_level_hold();
    t_eoi();
    t_write_service();
    t_mask();
    t_map();
    t_order();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(8 * 20000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule